// File: doc/BRIEF.md
# SPI Master Register Front End

This block is the software-visible register file of an SPI master controller. It sits on a 64-bit register bus that only supports whole, aligned 8-byte accesses. The register index is the byte address shifted right by three. Bit 63 is the most significant bit, and byte 0 of a word is bits 63:56. The block stores the configuration words that the serial engine consumes, the transmit and receive data words, and eight packed sequencer opcodes. It also keeps a small status word of full, overrun and underrun flags.

The shift engine is not part of this block. It reports through three strobes: `rx_load` delivers a received word, `tx_consume` signals that the transmit word was taken, and `tx_starved` signals that the engine ran out of data. Software can reset the clock-configuration register on its own by writing the pattern 0x5 and then 0xA into its 4-bit reset-control field. Read data comes back one cycle after the request, with a valid strobe.

Top module: `spictl_regfront`

## Requirements
- R1: Register index = byte address >> 3. An access is mapped only when address bits 2:0 are zero and the index is one of: 0 error, 1 counter config, 2 config, 3 clock config, 4 memory map, 5 transmit data, 6 receive data, 7 opcodes, 8 status. A misaligned access counts as unmapped.
- R2: An unmapped read returns 64'hFFFF_FFFF_FFFF_FFFF. Any unmapped access pulses `bus_err` in the following cycle, and an unmapped write changes no register.
- R3: A write to index 5 stores the word, sets TDR-full (status bit 61) and clears TDR-underrun (status bit 59).
- R4: A read of index 6 returns the receive word and clears RDR-full (status bit 63).
- R5: A write to index 3 whose bits 27:24 equal 0xA, made while the stored bits 27:24 equal 0x5, loads 64'h0618_0000_0000_0000. Every other write to index 3 stores the written word.
- R6: A write to index 7 loads opcode byte k from bits 63-8k down to 56-8k, for k = 0 to 7. A read reassembles the bytes in the same positions, and `seqop_o` carries the same word.
- R7: A status write loads RDR-overrun (bit 62) from written bit 62 and TDR-overrun (bit 60) from written bit 60. All other status bits ignore the write. Status bits 58:0 read as zero.
- R8: Indices 0, 1, 2, 4 and 6 are plain read/write storage and appear on their configuration outputs.
- R9: `rx_load` writes `rx_word` into index 6 and sets RDR-full. If RDR-full was already set, it also sets RDR-overrun. `tx_consume` clears TDR-full, and `tx_starved` sets TDR-underrun.
- R10: Synchronous reset clears every register and flag to zero, except clock config, which takes 64'h0618_0000_0000_0000.
- R11: Read data is registered. `bus_rvalid` is high exactly in the cycle after a read request, and `bus_rdata` holds the value from before that cycle's updates.
- R12: When a bus access and an engine strobe hit the same register or flag in one cycle, the engine wins on RDR-full, RDR-overrun and receive data. A bus write to index 5 wins over `tx_consume` and `tx_starved`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Access request, one cycle each |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 64 | Write data, big-endian |
| bus_rdata | output | 64 | Registered read data |
| bus_rvalid | output | 1 | Read data valid |
| bus_err | output | 1 | Unmapped or misaligned access |
| rx_load | input | 1 | Engine delivers a received word |
| rx_word | input | 64 | Received word |
| tx_consume | input | 1 | Engine took the transmit word |
| tx_starved | input | 1 | Engine found no transmit word |
| cfg_err_o | output | 64 | Error register |
| cfg_ctr_o | output | 64 | Counter config register |
| cfg_main_o | output | 64 | Config register |
| cfg_clk_o | output | 64 | Clock config register |
| cfg_mm_o | output | 64 | Memory-map register |
| tx_word_o | output | 64 | Transmit data register |
| seqop_o | output | 64 | Packed opcodes, byte 0 in bits 63:56 |
| stat_o | output | 5 | {RDR-full, RDR-overrun, TDR-full, TDR-overrun, TDR-underrun} |

## Verification
The assertions assume that every bus request lasts one cycle and that `bus_wr` and `bus_addr` are valid whenever `bus_req` is high. The engine strobes are treated as free-running single-cycle pulses. The random stimulus drives each request for exactly one cycle from a settled clock phase, so it stays inside these assumptions. It lets engine strobes land in the same cycle as bus accesses on purpose, which exercises the precedence rules. Writes to clock config are biased toward the field values 0x5 and 0xA, so that the unlock pattern and its broken variants occur often.

// File: rtl/spictl_pkg.sv
package spictl_pkg;
  localparam int DW      = 64;
  localparam int NBYTES  = DW / 8;
  localparam int NREG    = 9;

  localparam int IDX_ERR = 0;
  localparam int IDX_CTR = 1;
  localparam int IDX_CFG = 2;
  localparam int IDX_CLK = 3;
  localparam int IDX_MM  = 4;
  localparam int IDX_TXD = 5;
  localparam int IDX_RXD = 6;
  localparam int IDX_SEQ = 7;
  localparam int IDX_STS = 8;

  // registers with no side effects
  localparam logic [NREG-1:0] PLAIN_MASK = 9'b0_0101_0111;

  localparam int RSTF_LSB = 24;
  localparam int RSTF_W   = 4;
  localparam logic [RSTF_W-1:0] UNLOCK_FIRST  = 4'h5;
  localparam logic [RSTF_W-1:0] UNLOCK_SECOND = 4'hA;
  localparam logic [DW-1:0] CLK_HARD_VAL = 64'h0618_0000_0000_0000;

  localparam int ST_RDR_OVR = 62;
  localparam int ST_TDR_OVR = 60;
  localparam int ST_W       = 5;

  typedef struct packed {
    logic rdr_full;
    logic rdr_ovr;
    logic tdr_full;
    logic tdr_ovr;
    logic tdr_und;
  } stat_t;
endpackage

// File: rtl/spictl_decode.sv
module spictl_decode import spictl_pkg::*; #(
  parameter int ADDR_W = 8
) (
  input  logic              bus_req,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic [ADDR_W-4:0] idx,
  output logic              hit,
  output logic              rd_ok,
  output logic              wr_ok,
  output logic [NREG-1:0]   sel
);
  localparam int IDX_W = ADDR_W - 3;

  assign idx   = bus_addr[ADDR_W-1:3];
  assign hit   = (bus_addr[2:0] == 3'b000) && (idx < IDX_W'(NREG));
  assign rd_ok = bus_req && !bus_wr && hit;
  assign wr_ok = bus_req && bus_wr && hit;

  for (genvar i = 0; i < NREG; i++) begin : g_sel
    assign sel[i] = (idx == IDX_W'(i));
  end
endmodule

// File: rtl/spictl_clkcfg.sv
module spictl_clkcfg import spictl_pkg::*; (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] clk_q
);
  logic armed, trigger;

  assign armed   = clk_q[RSTF_LSB +: RSTF_W] == UNLOCK_FIRST;
  assign trigger = armed && (wdata[RSTF_LSB +: RSTF_W] == UNLOCK_SECOND);

  always_ff @(posedge clk) begin
    if (rst)        clk_q <= CLK_HARD_VAL;
    else if (wr_en) clk_q <= trigger ? CLK_HARD_VAL : wdata;
  end
endmodule

// File: rtl/spictl_seqop.sv
module spictl_seqop import spictl_pkg::*; (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] packed_o
);
  logic [7:0] op_q [NBYTES];

  for (genvar k = 0; k < NBYTES; k++) begin : g_byte
    always_ff @(posedge clk) begin
      if (rst)        op_q[k] <= '0;
      else if (wr_en) op_q[k] <= wdata[DW-1-8*k -: 8];
    end
    assign packed_o[DW-1-8*k -: 8] = op_q[k];
  end
endmodule

// File: rtl/spictl_status.sv
module spictl_status import spictl_pkg::*; (
  input  logic  clk,
  input  logic  rst,
  input  logic  tx_wr,
  input  logic  rx_rd,
  input  logic  st_wr,
  input  logic  wr_rovr,
  input  logic  wr_tovr,
  input  logic  rx_load,
  input  logic  tx_consume,
  input  logic  tx_starved,
  output stat_t stat_q
);
  stat_t nxt;

  always_comb begin
    nxt = stat_q;
    if (st_wr) begin
      nxt.rdr_ovr = wr_rovr;
      nxt.tdr_ovr = wr_tovr;
    end
    if (rx_rd) nxt.rdr_full = 1'b0;
    if (rx_load) begin
      if (stat_q.rdr_full) nxt.rdr_ovr = 1'b1;
      nxt.rdr_full = 1'b1;
    end
    if (tx_consume) nxt.tdr_full = 1'b0;
    if (tx_starved) nxt.tdr_und  = 1'b1;
    if (tx_wr) begin
      nxt.tdr_full = 1'b1;
      nxt.tdr_und  = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) stat_q <= '0;
    else     stat_q <= nxt;
  end
endmodule

// File: rtl/spictl_regfront.sv
module spictl_regfront import spictl_pkg::*; #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_req,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [63:0]       bus_wdata,
  output logic [63:0]       bus_rdata,
  output logic              bus_rvalid,
  output logic              bus_err,
  input  logic              rx_load,
  input  logic [63:0]       rx_word,
  input  logic              tx_consume,
  input  logic              tx_starved,
  output logic [63:0]       cfg_err_o,
  output logic [63:0]       cfg_ctr_o,
  output logic [63:0]       cfg_main_o,
  output logic [63:0]       cfg_clk_o,
  output logic [63:0]       cfg_mm_o,
  output logic [63:0]       tx_word_o,
  output logic [63:0]       seqop_o,
  output logic [4:0]        stat_o
);
  localparam int IDX_W = ADDR_W - 3;

  logic [IDX_W-1:0] idx;
  logic             hit, rd_ok, wr_ok;
  logic [NREG-1:0]  sel, wr_sel;
  logic [DW-1:0]    plain_q [NREG];
  logic [DW-1:0]    clk_q, seq_q, tx_q, rd_mux;
  stat_t            stat_q;

  spictl_decode #(.ADDR_W(ADDR_W)) u_dec (
    .bus_req(bus_req), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .idx(idx), .hit(hit), .rd_ok(rd_ok), .wr_ok(wr_ok), .sel(sel)
  );

  assign wr_sel = sel & {NREG{wr_ok}};

  for (genvar i = 0; i < NREG; i++) begin : g_plain
    if (PLAIN_MASK[i]) begin : g_store
      always_ff @(posedge clk) begin
        if (rst)                          plain_q[i] <= '0;
        else if (i == IDX_RXD && rx_load) plain_q[i] <= rx_word;
        else if (wr_sel[i])               plain_q[i] <= bus_wdata;
      end
    end else begin : g_none
      assign plain_q[i] = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                  tx_q <= '0;
    else if (wr_sel[IDX_TXD]) tx_q <= bus_wdata;
  end

  spictl_clkcfg u_clk (
    .clk(clk), .rst(rst), .wr_en(wr_sel[IDX_CLK]), .wdata(bus_wdata), .clk_q(clk_q)
  );

  spictl_seqop u_seq (
    .clk(clk), .rst(rst), .wr_en(wr_sel[IDX_SEQ]), .wdata(bus_wdata), .packed_o(seq_q)
  );

  spictl_status u_sts (
    .clk(clk), .rst(rst),
    .tx_wr(wr_sel[IDX_TXD]),
    .rx_rd(rd_ok && sel[IDX_RXD]),
    .st_wr(wr_sel[IDX_STS]),
    .wr_rovr(bus_wdata[ST_RDR_OVR]),
    .wr_tovr(bus_wdata[ST_TDR_OVR]),
    .rx_load(rx_load), .tx_consume(tx_consume), .tx_starved(tx_starved),
    .stat_q(stat_q)
  );

  always_comb begin
    case (idx)
      IDX_W'(IDX_ERR): rd_mux = plain_q[IDX_ERR];
      IDX_W'(IDX_CTR): rd_mux = plain_q[IDX_CTR];
      IDX_W'(IDX_CFG): rd_mux = plain_q[IDX_CFG];
      IDX_W'(IDX_CLK): rd_mux = clk_q;
      IDX_W'(IDX_MM):  rd_mux = plain_q[IDX_MM];
      IDX_W'(IDX_TXD): rd_mux = tx_q;
      IDX_W'(IDX_RXD): rd_mux = plain_q[IDX_RXD];
      IDX_W'(IDX_SEQ): rd_mux = seq_q;
      IDX_W'(IDX_STS): rd_mux = {stat_q, {(DW-ST_W){1'b0}}};
      default:         rd_mux = '1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
      bus_err    <= 1'b0;
    end else begin
      bus_rvalid <= bus_req && !bus_wr;
      bus_err    <= bus_req && !hit;
      if (bus_req && !bus_wr) bus_rdata <= hit ? rd_mux : '1;
    end
  end

  assign cfg_err_o  = plain_q[IDX_ERR];
  assign cfg_ctr_o  = plain_q[IDX_CTR];
  assign cfg_main_o = plain_q[IDX_CFG];
  assign cfg_mm_o   = plain_q[IDX_MM];
  assign cfg_clk_o  = clk_q;
  assign tx_word_o  = tx_q;
  assign seqop_o    = seq_q;
  assign stat_o     = stat_q;
endmodule

// File: rtl/spictl_chk.sv
module spictl_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_req,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [63:0]       bus_wdata,
  input logic [63:0]       bus_rdata,
  input logic              bus_rvalid,
  input logic              bus_err,
  input logic              rx_load,
  input logic [63:0]       cfg_err_o,
  input logic [63:0]       cfg_clk_o,
  input logic [4:0]        stat_o
);
  logic [ADDR_W-4:0] a_idx;
  logic              a_al, rd_req, wr_req;
  assign a_idx  = bus_addr[ADDR_W-1:3];
  assign a_al   = bus_addr[2:0] == 3'b000;
  assign rd_req = bus_req && !bus_wr;
  assign wr_req = bus_req && bus_wr;

  // R1: misaligned read is refused
  p_misalign_r1: assert property (@(posedge clk) disable iff (rst)
    rd_req && !a_al |=> bus_err && bus_rdata == 64'hFFFF_FFFF_FFFF_FFFF);

  // R2: index past the map reads all ones
  p_unmapped_r2: assert property (@(posedge clk) disable iff (rst)
    rd_req && a_al && a_idx > 8 |=> bus_err && bus_rdata == 64'hFFFF_FFFF_FFFF_FFFF);

  // R3
  p_tdr_set_r3: assert property (@(posedge clk) disable iff (rst)
    wr_req && a_al && a_idx == 5 |=> stat_o[2] && !stat_o[0]);

  // R4
  p_rdr_clr_r4: assert property (@(posedge clk) disable iff (rst)
    rd_req && a_al && a_idx == 6 && !rx_load |=> !stat_o[4]);

  // R5
  p_unlock_r5: assert property (@(posedge clk) disable iff (rst)
    wr_req && a_al && a_idx == 3 && cfg_clk_o[27:24] == 4'h5 && bus_wdata[27:24] == 4'hA
    |=> cfg_clk_o == 64'h0618_0000_0000_0000);

  // R8
  p_plain_r8: assert property (@(posedge clk) disable iff (rst)
    wr_req && a_al && a_idx == 0 |=> cfg_err_o == $past(bus_wdata));

  // R9
  p_overrun_r9: assert property (@(posedge clk) disable iff (rst)
    rx_load && stat_o[4] |=> stat_o[4] && stat_o[3]);

  // R11
  p_rvalid_r11: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> bus_rvalid);
  p_no_rvalid_r11: assert property (@(posedge clk) disable iff (rst)
    !rd_req |=> !bus_rvalid);
endmodule

bind spictl_regfront spictl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .bus_req(bus_req), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
  .bus_err(bus_err), .rx_load(rx_load), .cfg_err_o(cfg_err_o),
  .cfg_clk_o(cfg_clk_o), .stat_o(stat_o)
);

// File: tb/tb_spictl_regfront.sv
module tb_spictl_regfront;
  localparam logic [63:0] HARD = 64'h0618_0000_0000_0000;
  localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;

  logic clk = 1'b0, rst = 1'b1;
  logic bus_req = 0, bus_wr = 0, rx_load = 0, tx_consume = 0, tx_starved = 0;
  logic [7:0]  bus_addr = '0;
  logic [63:0] bus_wdata = '0, rx_word = '0;
  logic [63:0] bus_rdata, cfg_err_o, cfg_ctr_o, cfg_main_o, cfg_clk_o, cfg_mm_o, tx_word_o, seqop_o;
  logic        bus_rvalid, bus_err;
  logic [4:0]  stat_o;

  always #4 clk = ~clk;

  spictl_regfront #(.ADDR_W(8)) dut (.*);

  int checks = 0, fails = 0;
  bit done = 0;

  // model: m[0..7] registers, ms = {rdrf, rovr, tdrf, tovr, und}
  logic [63:0] m [9];
  logic [4:0]  ms;

  task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic logic [63:0] mread(input int i);
    if (i == 8) return {ms, 59'b0};
    return m[i];
  endfunction

  task automatic mreset();
    for (int i = 0; i < 9; i++) m[i] = '0;
    m[3] = HARD;
    ms = '0;
  endtask

  task automatic step(input logic req, input logic wr, input logic [7:0] addr,
                      input logic [63:0] wd, input logic ld, input logic [63:0] lw,
                      input logic cons, input logic starve);
    int idx; bit hit; logic [63:0] erd; logic [4:0] ns;
    idx = int'(addr >> 3);
    hit = (addr[2:0] == 0) && idx < 9;
    erd = hit ? mread(idx) : ONES;
    bus_req = req; bus_wr = wr; bus_addr = addr; bus_wdata = wd;
    rx_load = ld; rx_word = lw; tx_consume = cons; tx_starved = starve;
    // model next state
    ns = ms;
    if (req && wr && hit) begin
      case (idx)
        3: m[3] = (m[3][27:24] == 4'h5 && wd[27:24] == 4'hA) ? HARD : wd;
        5: m[5] = wd;
        8: begin ns[3] = wd[62]; ns[1] = wd[60]; end
        default: m[idx] = wd;
      endcase
    end
    if (req && !wr && hit && idx == 6) ns[4] = 1'b0;
    if (ld) begin
      m[6] = lw;
      if (ms[4]) ns[3] = 1'b1;
      ns[4] = 1'b1;
    end
    if (cons)   ns[2] = 1'b0;
    if (starve) ns[0] = 1'b1;
    if (req && wr && hit && idx == 5) begin ns[2] = 1'b1; ns[0] = 1'b0; end
    ms = ns;
    @(negedge clk);
    bus_req = 0; rx_load = 0; tx_consume = 0; tx_starved = 0;
    chk("R11 rvalid", 64'(bus_rvalid), 64'(req && !wr));
    chk("R2 err", 64'(bus_err), 64'(req && !hit));
    if (req && !wr) chk(hit ? "R11 rdata" : "R2 rdata", bus_rdata, erd);
    chk("R9 status", 64'(stat_o), 64'(ms));
    chk("R8 err reg", cfg_err_o, m[0]);
    chk("R8 ctr reg", cfg_ctr_o, m[1]);
    chk("R8 cfg reg", cfg_main_o, m[2]);
    chk("R5 clk reg", cfg_clk_o, m[3]);
    chk("R8 mm reg", cfg_mm_o, m[4]);
    chk("R3 tx reg", tx_word_o, m[5]);
    chk("R6 seqop", seqop_o, m[7]);
  endtask

  task automatic wr_(input int i, input logic [63:0] d);
    step(1, 1, 8'(i * 8), d, 0, '0, 0, 0);
  endtask
  task automatic rd_(input int i);
    step(1, 0, 8'(i * 8), '0, 0, '0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [63:0] d;
    void'($urandom(32'd20240611));
    mreset();
    repeat (3) @(negedge clk);
    rst = 0;
    // R10 reset state
    chk("R10 clk", cfg_clk_o, HARD);
    chk("R10 status", 64'(stat_o), 64'd0);
    chk("R10 seqop", seqop_o, 64'd0);
    chk("R10 rvalid", 64'(bus_rvalid), 64'd0);

    // R6 byte order
    wr_(7, 64'h0102_0304_0506_0708);
    rd_(7);
    chk("R6 byte0", 64'(seqop_o[63:56]), 64'h01);
    chk("R6 byte7", 64'(seqop_o[7:0]), 64'h08);

    // R5 unlock and broken variants
    wr_(3, 64'h0000_0000_0500_1234);
    wr_(3, 64'h0000_0000_0A00_0000);
    chk("R5 unlock", cfg_clk_o, HARD);
    wr_(3, 64'h0000_0000_0A00_0001);
    chk("R5 no arm", cfg_clk_o, 64'h0000_0000_0A00_0001);
    wr_(3, 64'h0000_0000_0500_0000);
    wr_(3, 64'h0000_0000_0300_0000);
    wr_(3, 64'h0000_0000_0A00_0000);
    chk("R5 broken", cfg_clk_o, 64'h0000_0000_0A00_0000);

    // R3 / R9 transmit flags, R12 write beats consume
    step(0, 0, 0, 0, 0, 0, 0, 1);
    wr_(5, 64'hDEAD_BEEF_0000_0001);
    chk("R3 flags", 64'(stat_o[2:0]), 64'b100);
    step(1, 1, 8'd40, 64'h55, 0, 0, 1, 1);
    chk("R12 tx wins", 64'(stat_o[2:0]), 64'b100);

    // R9 receive, overrun, R4 read clears, R12 load beats read
    step(0, 0, 0, 0, 1, 64'hAAAA, 0, 0);
    step(0, 0, 0, 0, 1, 64'hBBBB, 0, 0);
    chk("R9 overrun", 64'(stat_o[4:3]), 64'b11);
    rd_(6);
    chk("R4 rdata", bus_rdata, 64'hBBBB);
    chk("R4 cleared", 64'(stat_o[4]), 64'd0);
    step(1, 0, 8'd48, 0, 1, 64'hCCCC, 0, 0);
    chk("R12 load wins", 64'(stat_o[4]), 64'd1);

    // R7 status write only touches overruns
    wr_(8, ONES);
    rd_(8);
    wr_(8, 64'd0);
    chk("R7 ovr clear", 64'(stat_o[3] | stat_o[1]), 64'd0);

    // R1/R2 misaligned and unmapped
    step(1, 1, 8'd9, ONES, 0, 0, 0, 0);
    step(1, 0, 8'd9, 0, 0, 0, 0, 0);
    step(1, 1, 8'd80, ONES, 0, 0, 0, 0);
    rd_(13);

    // random phase
    for (int n = 0; n < 4000; n++) begin
      logic [7:0] a;
      a = 8'($urandom_range(0, 11) * 8);
      if ($urandom_range(0, 15) == 0) a = a | 8'($urandom_range(1, 7));
      d = {$urandom, $urandom};
      case ($urandom_range(0, 3))
        0: d[27:24] = 4'h5;
        1: d[27:24] = 4'hA;
        default: ;
      endcase
      step($urandom_range(0, 3) != 0, $urandom_range(0, 1) == 1, a, d,
           $urandom_range(0, 3) == 0, {$urandom, $urandom},
           $urandom_range(0, 4) == 0, $urandom_range(0, 9) == 0);
    end

    // R10 reset mid-run
    rst = 1; mreset();
    @(negedge clk); rst = 0;
    chk("R10 reapply clk", cfg_clk_o, HARD);
    chk("R10 reapply status", 64'(stat_o), 64'd0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule